// File: doc/BRIEF.md
# Fetch-Bundle Vector-Type Hazard Pre-Decoder

This block looks at a whole fetch bundle before the main decoder does and tags each instruction slot with four flags. It marks vector-configuration instructions, which write the vector type state, and instructions that read that state. It also marks any reader that sits after a valid configuration write in the same bundle, because a stateless per-slot decoder cannot see that dependency. A fourth flag is a coarse hint that a slot may transfer control. The block only reports these conditions. Deciding whether to stall, rename or forward is left to later stages.

The logic is purely combinational. A clock and an active-low reset are on the port list but do not affect any output. They are there so that a register stage can be added later without changing the interface. Per-slot classification and the cross-slot prefix scan sit in separate modules under a thin top.

Top module: `bundle_predecode`

## Requirements
- R1: Outputs depend only on the current inputs. They change without waiting for a clock edge, and holding reset low does not change them.
- R2: A valid slot with opcode bits[6:0]=0x57 and funct3 bits[14:12]=3'b111 sets isVcfg. This holds for all three config forms, which differ only in bits[31:30] (0x, 10, 11).
- R3: A valid slot with opcode 0x57 and funct3 other than 3'b111 sets needsVtype and clears isVcfg.
- R4: A valid slot with opcode 0x07 or 0x27 sets needsVtype when funct3 is 000, 101, 110 or 111 (vector element widths). It does not set needsVtype for 001, 010, 011 or 100.
- R5: A whole-register vector transfer does not set needsVtype. This is opcode 0x07 or 0x27 with a vector width, bits[27:26]=2'b00 and bits[24:20]=5'b01000. When bits[27:26] is not 00, the same bits[24:20] value still sets needsVtype.
- R6: vtypeHazard[i] is set exactly when needsVtype[i] is set and some slot j<i is valid with isVcfg set. A config slot does not need vtype, so it never has a hazard itself.
- R7: Slot 0 never has vtypeHazard set. A config instruction in a later slot does not raise a hazard in an earlier slot.
- R8: When a slot's valid bit is 0, all four of its outputs are 0. An invalid config slot raises no hazard in any later slot.
- R9: A valid slot with opcode 0x6F, 0x67 or 0x63 sets mayBranch whatever its other bits hold, including reserved funct3 values.
- R10: A valid slot with any other opcode (for example 0x13, 0x33 or 0x53) sets none of the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, reserved for a future register stage; used only by checks |
| rst_n | input | 1 | Active-low reset, reserved; used only by checks |
| slotValid | input | NUM_SLOTS | Per-slot valid bits |
| bundleInstr | input | NUM_SLOTS*INSTR_W | Bundle instructions; slot k occupies bits [k*INSTR_W +: INSTR_W] |
| isVcfg | output | NUM_SLOTS | Slot is a vector-configuration instruction |
| needsVtype | output | NUM_SLOTS | Slot reads the vector type state |
| vtypeHazard | output | NUM_SLOTS | Earlier valid config slot in this bundle writes the type this slot reads |
| mayBranch | output | NUM_SLOTS | Conservative control-flow hint |

## Verification
The bench builds the block with its defaults: eight slots of 32-bit instructions. With these values it can reach both ends of the prefix scan, from a config in slot 0 that hazards all seven readers to a config in slot 7 that hazards nothing. The classification table places each encoding in a rotating slot, so every slot position decodes at least one instruction. Directed bundles then cover invalid config slots, back-to-back config instructions, and outputs driven while reset is held.

// File: rtl/predec_pkg.sv
package predec_pkg;
  localparam logic [6:0] OPC_VEC   = 7'h57;
  localparam logic [6:0] OPC_VLDFP = 7'h07;
  localparam logic [6:0] OPC_VSTFP = 7'h27;
  localparam logic [6:0] OPC_JAL   = 7'h6F;
  localparam logic [6:0] OPC_JALR  = 7'h67;
  localparam logic [6:0] OPC_BR    = 7'h63;
  localparam logic [2:0] F3_CFG    = 3'b111;
  localparam logic [1:0] MOP_UNIT  = 2'b00;
  localparam logic [4:0] SEL_WHOLE = 5'b01000;

  typedef struct packed {
    logic isCfg;
    logic useVtype;
    logic maybeBr;
  } slotStrobe_t;
endpackage

// File: rtl/predec_slot_dp.sv
module predec_slot_dp
  import predec_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               slotValid,
  input  logic [INSTR_W-1:0] instr,
  output slotStrobe_t        strobe
);
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [1:0] memMode;
  logic [4:0] subSel;
  logic       vecWidth;
  logic       memOp;
  logic       wholeReg;
  logic       unusedBits;

  assign opcode  = instr[6:0];
  assign funct3  = instr[14:12];
  assign memMode = instr[27:26];
  assign subSel  = instr[24:20];
  assign unusedBits = ^{instr[INSTR_W-1:28], instr[25], instr[19:15], instr[11:7]};

  always_comb begin
    unique case (funct3)
      3'b000, 3'b101, 3'b110, 3'b111: vecWidth = 1'b1;
      default:                        vecWidth = 1'b0;
    endcase
  end

  assign memOp    = (opcode == OPC_VLDFP) || (opcode == OPC_VSTFP);
  assign wholeReg = (memMode == MOP_UNIT) && (subSel == SEL_WHOLE);

  always_comb begin
    strobe = '0;
    if (slotValid) begin
      strobe.isCfg    = (opcode == OPC_VEC) && (funct3 == F3_CFG);
      strobe.useVtype = ((opcode == OPC_VEC) && (funct3 != F3_CFG)) ||
                        (memOp && vecWidth && !wholeReg);
      strobe.maybeBr  = (opcode == OPC_JAL) || (opcode == OPC_JALR) ||
                        (opcode == OPC_BR);
    end
  end
endmodule

// File: rtl/predec_hazard_ctl.sv
module predec_hazard_ctl
  import predec_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  slotStrobe_t          strobes [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0] hazard
);
  logic [NUM_SLOTS-1:0] cfgLive;
  logic [NUM_SLOTS-1:0] readVec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign cfgLive[s] = slotValid[s] & strobes[s].isCfg;
    assign readVec[s] = strobes[s].useVtype;
    if (s == 0) begin : g_first
      assign hazard[s] = 1'b0;
    end else begin : g_rest
      assign hazard[s] = readVec[s] & (|cfgLive[s-1:0]);
    end
  end

  // R6
  hazard_needs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hazard & ~readVec) == '0);
  // R7
  slot0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hazard[0]);
  // R8
  no_cfg_no_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cfgLive) == 0) |-> (hazard == '0));
endmodule

// File: rtl/bundle_predecode.sv
module bundle_predecode
  import predec_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int INSTR_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SLOTS-1:0]         slotValid,
  input  logic [NUM_SLOTS*INSTR_W-1:0] bundleInstr,
  output logic [NUM_SLOTS-1:0]         isVcfg,
  output logic [NUM_SLOTS-1:0]         needsVtype,
  output logic [NUM_SLOTS-1:0]         vtypeHazard,
  output logic [NUM_SLOTS-1:0]         mayBranch
);
  slotStrobe_t strobes [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dp
    predec_slot_dp #(.INSTR_W(INSTR_W)) u_dp (
      .slotValid (slotValid[s]),
      .instr     (bundleInstr[s*INSTR_W +: INSTR_W]),
      .strobe    (strobes[s])
    );
    assign isVcfg[s]     = strobes[s].isCfg;
    assign needsVtype[s] = strobes[s].useVtype;
    assign mayBranch[s]  = strobes[s].maybeBr;
  end

  predec_hazard_ctl #(.NUM_SLOTS(NUM_SLOTS)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slotValid (slotValid),
    .strobes   (strobes),
    .hazard    (vtypeHazard)
  );

  // R8
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~slotValid) & (isVcfg | needsVtype | mayBranch | vtypeHazard)) == '0);
  // R3
  cfg_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isVcfg & needsVtype) == '0);
  // R9
  branch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mayBranch & (isVcfg | needsVtype)) == '0);
endmodule

// File: tb/bundle_predecode_tb.sv
module bundle_predecode_tb;
  localparam int NS = 8;
  localparam int IW = 32;
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] CFG = 32'h0000_7057;
  localparam logic [31:0] VAD = 32'h0000_0057;
  localparam logic [31:0] VLE = 32'h0000_6007;
  localparam logic [31:0] ADD = 32'h0000_0033;

  typedef struct packed {
    logic [31:0] ins;
    logic        expCfg;
    logic        expNeed;
    logic        expBr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    {32'h0000_7057, 3'b100},  // R2 reg-imm vtype form
    {32'h8000_7057, 3'b100},  // R2 reg-reg form
    {32'hC000_7057, 3'b100},  // R2 imm-AVL form
    {32'h0000_0057, 3'b010},  // R3 funct3 000
    {32'h0000_2057, 3'b010},  // R3 funct3 010
    {32'h0000_6057, 3'b010},  // R3 funct3 110
    {32'h0000_0007, 3'b010},  // R4 load w000
    {32'h0000_6007, 3'b010},  // R4 load w110
    {32'h0000_7027, 3'b010},  // R4 store w111
    {32'h0000_5027, 3'b010},  // R4 store w101
    {32'h0000_2007, 3'b000},  // R4 scalar w010
    {32'h0000_3007, 3'b000},  // R4 scalar w011
    {32'h0000_4027, 3'b000},  // R4 scalar w100
    {32'h0000_1007, 3'b000},  // R4 unused w001
    {32'h0080_6007, 3'b000},  // R5 whole load
    {32'h0080_0027, 3'b000},  // R5 whole store
    {32'h0880_6007, 3'b010},  // R5 strided same sel
    {32'h0000_006F, 3'b001},  // R9 jal
    {32'h0000_5067, 3'b001},  // R9 jalr reserved funct3
    {32'h0000_7063, 3'b001},  // R9 branch
    {32'h0000_0013, 3'b000},  // R10 op-imm
    {32'h0000_0033, 3'b000},  // R10 op
    {32'h0000_7053, 3'b000},  // R10 fp op
    {32'hFFFF_F037, 3'b000}   // R10 lui
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] slotValid = '0;
  logic [NS*IW-1:0] bundleInstr = '0;
  logic [NS-1:0] isVcfg, needsVtype, vtypeHazard, mayBranch;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bundle_predecode #(.NUM_SLOTS(NS), .INSTR_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .bundleInstr(bundleInstr),
    .isVcfg(isVcfg), .needsVtype(needsVtype), .vtypeHazard(vtypeHazard),
    .mayBranch(mayBranch)
  );

  task automatic cmp(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic [NS-1:0] c, input logic [NS-1:0] n,
                          input logic [NS-1:0] h, input logic [NS-1:0] b);
    #5;
    cmp({tag, " isVcfg"}, isVcfg, c);
    cmp({tag, " needsVtype"}, needsVtype, n);
    cmp({tag, " vtypeHazard"}, vtypeHazard, h);
    cmp({tag, " mayBranch"}, mayBranch, b);
  endtask

  task automatic fillNop();
    for (int k = 0; k < NS; k++) bundleInstr[k*IW +: IW] = NOP;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    // R8 reset state: all slots invalid
    #3;
    checkAll("R8 reset", '0, '0, '0, '0);
    // R1 outputs follow inputs while reset held
    fillNop();
    bundleInstr[2*IW +: IW] = CFG;
    bundleInstr[5*IW +: IW] = VAD;
    slotValid = '1;
    checkAll("R1 in reset", 8'b0000_0100, 8'b0010_0000, 8'b0010_0000, '0);
    #40 rst_n = 1'b1;
    @(negedge clk);

    // table walk: entry placed in a rotating slot
    for (int e = 0; e < NV; e++) begin
      int sl;
      sl = e % NS;
      fillNop();
      bundleInstr[sl*IW +: IW] = TBL[e].ins;
      slotValid = '1;
      checkAll($sformatf("R2-R10 tbl%0d", e), NS'(TBL[e].expCfg) << sl,
               NS'(TBL[e].expNeed) << sl, '0, NS'(TBL[e].expBr) << sl);
    end

    // R6 mixed bundle
    fillNop();
    bundleInstr[1*IW +: IW] = VAD;
    bundleInstr[3*IW +: IW] = CFG;
    bundleInstr[4*IW +: IW] = VAD;
    bundleInstr[6*IW +: IW] = VLE;
    bundleInstr[7*IW +: IW] = ADD;
    slotValid = '1;
    checkAll("R6 mixed", 8'b0000_1000, 8'b0101_0010, 8'b0101_0000, '0);

    // R7 config in slot 0, readers everywhere else
    for (int k = 1; k < NS; k++) bundleInstr[k*IW +: IW] = VAD;
    bundleInstr[0 +: IW] = CFG;
    checkAll("R7 cfg slot0", 8'b0000_0001, 8'b1111_1110, 8'b1111_1110, '0);

    // R7 reader in slot 0, config last
    fillNop();
    bundleInstr[0 +: IW] = VAD;
    bundleInstr[7*IW +: IW] = CFG;
    checkAll("R7 later cfg", 8'b1000_0000, 8'b0000_0001, '0, '0);

    // R6 back-to-back config: second config has no hazard
    fillNop();
    bundleInstr[0 +: IW] = CFG;
    bundleInstr[1*IW +: IW] = CFG;
    bundleInstr[2*IW +: IW] = VLE;
    checkAll("R6 cfg pair", 8'b0000_0011, 8'b0000_0100, 8'b0000_0100, '0);

    // R8 invalid config slot raises nothing
    fillNop();
    bundleInstr[2*IW +: IW] = CFG;
    for (int k = 3; k < NS; k++) bundleInstr[k*IW +: IW] = VAD;
    slotValid = 8'b1111_1011;
    checkAll("R8 invalid cfg", '0, 8'b1111_1000, '0, '0);

    // R8 invalid branch and reader slots quiet
    fillNop();
    bundleInstr[0 +: IW] = CFG;
    bundleInstr[3*IW +: IW] = 32'h0000_006F;
    bundleInstr[4*IW +: IW] = VAD;
    bundleInstr[5*IW +: IW] = VAD;
    slotValid = 8'b1110_0111;
    checkAll("R8 invalid mix", 8'b0000_0001, 8'b0010_0000, 8'b0010_0000, '0);

    // R1 change mid-cycle seen without an edge
    @(posedge clk);
    #2;
    slotValid = '1;
    checkAll("R1 async", 8'b0000_0001, 8'b0011_0000, 8'b0011_0000, 8'b0000_1000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule